// File: doc/BRIEF.md
# Periodic Checkpoint and Rollback Controller

This block orders the saving and recovery of architectural state for a small register-state core. The core's state is a PC word plus a register file, NW = NREGS + 1 words in all. Every PERIOD cycles of normal execution, the block stalls the core and copies the state into protected storage, one word per cycle. The core presents the word the block selects on the snapshot bus. The storage has two slots, used in turn. A slot counts as good only once its final word is written and no disturbance was seen during the write.

When the interference-detect input rises, the block freezes the core and waits for the input to fall. It then streams the newest good slot back to the core over the restore bus, one word per strobe cycle, and restarts the periodic timer. If no good slot exists yet, it streams the power-on image instead.

A sticky flag reports disturbances that come closer together than the minimum interval needed for forward progress.

Top module: `ckr_ctrl`

## Requirements
- R1: During and after reset, `core_stall_o`, `restore_stb_o` and `progress_violation_o` are low, and neither storage slot holds a good checkpoint.
- R2: `core_stall_o` first rises after exactly PERIOD clock edges following reset release, if no detection occurs. It then stays high for exactly NW cycles while `snap_sel_o` steps 0,1,…,NW-1. Word 0 is the PC and word k is register k-1.
- R3: After a restore completes, the next checkpoint stall begins exactly PERIOD clock edges later, if no detection occurs.
- R4: After any edge at which `detect_i` is sampled high, `core_stall_o` is high and `restore_stb_o` is low in the following cycle.
- R5: The restore begins in the cycle after the first edge at which `detect_i` is sampled low. `restore_stb_o` is then high for exactly NW consecutive cycles, with `restore_sel_o` stepping 0..NW-1. `core_stall_o` falls in the cycle after the last word.
- R6: The words on `restore_word_o` equal the core state captured by the most recently committed checkpoint.
- R7: A checkpoint commits only if `detect_i` is low at every edge of its write. A write interrupted by a detection never disturbs the previously committed slot, and that older slot is what gets restored.
- R8: If no checkpoint has committed since reset, the restore stream is the power-on image: word 0 equals RESET_PC and all other words are zero.
- R9: A detection during a restore returns the block to the waiting phase. Once `detect_i` falls, the full restore restarts from word 0.
- R10: Let k be the number of clock edges between the edge that completes a restore and the next edge at which a detection starts a rollback. `progress_violation_o` sets when k < MIN_GAP. It stays set until reset, and it cannot set before the first restore has completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| detect_i | input | 1 | Interference-detect level |
| snap_word_i | input | DW | State word from the core, selected by `snap_sel_o` |
| snap_sel_o | output | IW | Index of the state word being saved |
| core_stall_o | output | 1 | Freezes the core |
| restore_stb_o | output | 1 | Core loads `restore_word_o` into word `restore_sel_o` |
| restore_sel_o | output | IW | Index of the word being restored |
| restore_word_o | output | DW | Restored state word |
| progress_violation_o | output | 1 | Sticky: detections too close together |

## Verification
A wrong slot pointer or valid bit is invisible until the next rollback. At that point, every restored word carries the wrong value, so the bench compares each restored word against an image it rebuilds from the number of cycles the core actually ran. An off-by-one in the period timer or the gap counter shifts the rise of `core_stall_o` by a cycle, or flips `progress_violation_o` at the k = MIN_GAP-1 / MIN_GAP boundary. The bench therefore counts edges from reset and from each restore completion, and probes both sides of the gap limit. A write interrupted mid-way shows up only as a restore of the newer, partial image, which the mid-write test targets directly.

// File: rtl/ckr_pkg.sv
package ckr_pkg;

    typedef enum logic [1:0] {
        CK_RUN  = 2'd0,
        CK_SAVE = 2'd1,
        CK_HOLD = 2'd2,
        CK_LOAD = 2'd3
    } ck_phase_e;

    typedef struct packed {
        logic save_open;
        logic save_word;
        logic save_commit;
        logic load_done;
        logic new_event;
    } ck_strobe_t;

    function automatic logic is_last(input int unsigned idx, input int unsigned count);
        return idx == count - 1;
    endfunction

endpackage

// File: rtl/ckr_period_timer.sv
module ckr_period_timer #(
    parameter int unsigned PERIOD = 128,
    localparam int unsigned CW = (PERIOD > 1) ? $clog2(PERIOD) : 1
) (
    input  logic clk,
    input  logic rst,
    input  logic run_i,
    input  logic clear_i,
    output logic expire_o
);
    logic [CW-1:0] cnt_q;
    logic          at_end;

    assign at_end   = (cnt_q == CW'(PERIOD - 1));
    assign expire_o = run_i && at_end;

    always_ff @(posedge clk) begin
        if (rst || clear_i) begin
            cnt_q <= '0;
        end else if (run_i) begin
            cnt_q <= at_end ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/ckr_safe_store.sv
module ckr_safe_store #(
    parameter int unsigned NW = 9,
    parameter int unsigned DW = 16,
    localparam int unsigned IW = (NW > 1) ? $clog2(NW) : 1,
    localparam int unsigned NSLOT = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          open_i,
    input  logic          wr_en_i,
    input  logic [IW-1:0] wr_idx_i,
    input  logic [DW-1:0] wr_data_i,
    input  logic          commit_i,
    input  logic [IW-1:0] rd_idx_i,
    output logic [DW-1:0] rd_data_o,
    output logic          good_o
);
    logic             newest_q;
    logic [NSLOT-1:0] valid_q;
    logic             target;
    logic [DW-1:0]    slot_rd [NSLOT];

    assign target = ~newest_q;

    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        logic [DW-1:0] words [NW];
        always_ff @(posedge clk) begin
            if (wr_en_i && (target == 1'(g))) begin
                words[wr_idx_i] <= wr_data_i;
            end
        end
        assign slot_rd[g] = words[rd_idx_i];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q  <= '0;
            newest_q <= 1'b0;
        end else begin
            if (open_i) begin
                valid_q[target] <= 1'b0;
            end
            if (commit_i) begin
                valid_q[target] <= 1'b1;
                newest_q        <= target;
            end
        end
    end

    assign rd_data_o = slot_rd[newest_q];
    assign good_o    = valid_q[newest_q];
endmodule

// File: rtl/ckr_gap_monitor.sv
module ckr_gap_monitor #(
    parameter int unsigned MIN_GAP = 512,
    localparam int unsigned GW = $clog2(MIN_GAP + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic done_i,
    input  logic event_i,
    output logic violation_o
);
    logic [GW-1:0] gap_q;
    logic          armed_q;
    logic          too_soon;

    assign too_soon = armed_q && (gap_q < GW'(MIN_GAP - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_q       <= '0;
            armed_q     <= 1'b0;
            violation_o <= 1'b0;
        end else begin
            if (done_i) begin
                gap_q   <= '0;
                armed_q <= 1'b1;
            end else if (gap_q != GW'(MIN_GAP)) begin
                gap_q <= gap_q + 1'b1;
            end
            if (event_i && too_soon) begin
                violation_o <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/ckr_ctrl.sv
module ckr_ctrl
    import ckr_pkg::*;
#(
    parameter int unsigned NREGS    = 8,
    parameter int unsigned DW       = 16,
    parameter int unsigned PERIOD   = 128,
    parameter int unsigned MIN_GAP  = 512,
    parameter int unsigned RESET_PC = 32'h100,
    localparam int unsigned NW = NREGS + 1,
    localparam int unsigned IW = $clog2(NW)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          detect_i,
    input  logic [DW-1:0] snap_word_i,
    output logic [IW-1:0] snap_sel_o,
    output logic          core_stall_o,
    output logic          restore_stb_o,
    output logic [IW-1:0] restore_sel_o,
    output logic [DW-1:0] restore_word_o,
    output logic          progress_violation_o
);
    ck_phase_e     phase_q, phase_d;
    logic [IW-1:0] idx_q, idx_d;
    ck_strobe_t    stb;
    logic          expire;
    logic          word_last;
    logic [DW-1:0] slot_word;
    logic          slot_good;

    assign word_last = is_last(32'(idx_q), NW);

    always_comb begin
        phase_d = phase_q;
        idx_d   = idx_q;
        stb     = '0;
        unique case (phase_q)
            CK_RUN: begin
                if (detect_i) begin
                    stb.new_event = 1'b1;
                    phase_d       = CK_HOLD;
                end else if (expire) begin
                    phase_d = CK_SAVE;
                    idx_d   = '0;
                end
            end
            CK_SAVE: begin
                stb.save_word = 1'b1;
                stb.save_open = (idx_q == '0);
                if (detect_i) begin
                    stb.new_event = 1'b1;
                    phase_d       = CK_HOLD;
                end else if (word_last) begin
                    stb.save_commit = 1'b1;
                    phase_d         = CK_RUN;
                    idx_d           = '0;
                end else begin
                    idx_d = idx_q + 1'b1;
                end
            end
            CK_HOLD: begin
                idx_d = '0;
                if (!detect_i) begin
                    phase_d = CK_LOAD;
                end
            end
            CK_LOAD: begin
                if (detect_i) begin
                    phase_d = CK_HOLD;
                    idx_d   = '0;
                end else if (word_last) begin
                    stb.load_done = 1'b1;
                    phase_d       = CK_RUN;
                    idx_d         = '0;
                end else begin
                    idx_d = idx_q + 1'b1;
                end
            end
            default: begin
                phase_d = CK_RUN;
                idx_d   = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= CK_RUN;
            idx_q   <= '0;
        end else begin
            phase_q <= phase_d;
            idx_q   <= idx_d;
        end
    end

    ckr_period_timer #(
        .PERIOD (PERIOD)
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .run_i    (phase_q == CK_RUN),
        .clear_i  (stb.load_done),
        .expire_o (expire)
    );

    ckr_safe_store #(
        .NW (NW),
        .DW (DW)
    ) u_store (
        .clk       (clk),
        .rst       (rst),
        .open_i    (stb.save_open),
        .wr_en_i   (stb.save_word),
        .wr_idx_i  (idx_q),
        .wr_data_i (snap_word_i),
        .commit_i  (stb.save_commit),
        .rd_idx_i  (idx_q),
        .rd_data_o (slot_word),
        .good_o    (slot_good)
    );

    ckr_gap_monitor #(
        .MIN_GAP (MIN_GAP)
    ) u_gap (
        .clk         (clk),
        .rst         (rst),
        .done_i      (stb.load_done),
        .event_i     (stb.new_event),
        .violation_o (progress_violation_o)
    );

    assign snap_sel_o     = idx_q;
    assign restore_sel_o  = idx_q;
    assign core_stall_o   = (phase_q != CK_RUN);
    assign restore_stb_o  = (phase_q == CK_LOAD);
    assign restore_word_o = slot_good ? slot_word
                          : ((idx_q == '0) ? DW'(RESET_PC) : '0);
endmodule

// File: rtl/ckr_ctrl_chk.sv
module ckr_ctrl_chk #(
    parameter int unsigned NW = 9,
    localparam int unsigned IW = $clog2(NW)
) (
    input logic          clk,
    input logic          rst,
    input logic          detect_i,
    input logic [IW-1:0] snap_sel_o,
    input logic          core_stall_o,
    input logic          restore_stb_o,
    input logic [IW-1:0] restore_sel_o,
    input logic          progress_violation_o
);
    a_r4_detect_freezes: assert property (@(posedge clk) disable iff (rst)
        detect_i |=> core_stall_o);

    a_r4_no_load_under_detect: assert property (@(posedge clk) disable iff (rst)
        detect_i |=> !restore_stb_o);

    a_r5_load_from_zero: assert property (@(posedge clk) disable iff (rst)
        $rose(restore_stb_o) |-> (restore_sel_o == '0));

    a_r5_load_steps: assert property (@(posedge clk) disable iff (rst)
        (restore_stb_o && !detect_i && (restore_sel_o != IW'(NW - 1)))
        |=> (restore_stb_o && (restore_sel_o == $past(restore_sel_o) + 1'b1)));

    a_r5_load_releases: assert property (@(posedge clk) disable iff (rst)
        (restore_stb_o && !detect_i && (restore_sel_o == IW'(NW - 1))) |=> !core_stall_o);

    a_r2_sel_in_range: assert property (@(posedge clk) disable iff (rst)
        core_stall_o |-> (snap_sel_o < IW'(NW)));

    a_r10_flag_sticky: assert property (@(posedge clk) disable iff (rst)
        progress_violation_o |=> progress_violation_o);
endmodule

bind ckr_ctrl ckr_ctrl_chk #(.NW(NW)) u_chk (
    .clk                  (clk),
    .rst                  (rst),
    .detect_i             (detect_i),
    .snap_sel_o           (snap_sel_o),
    .core_stall_o         (core_stall_o),
    .restore_stb_o        (restore_stb_o),
    .restore_sel_o        (restore_sel_o),
    .progress_violation_o (progress_violation_o)
);

// File: tb/sim_ckr_ctrl.sv
module sim_ckr_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int NREGS = 8;
    localparam int DW = 16;
    localparam int PERIOD = 128;
    localparam int MIN_GAP = 512;
    localparam int RESET_PC = 'h100;
    localparam int NW = NREGS + 1;
    localparam int IW = $clog2(NW);
    // wait before detect, detect length, expected violation flag
    localparam int NTBL = 5;
    localparam int TBL [NTBL][3] = '{
        '{300, 3, 0}, '{600, 1, 0}, '{700, 12, 0}, '{530, 5, 0}, '{200, 2, 1}};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic detect = 1'b0;
    logic [DW-1:0] snap_word;
    logic [IW-1:0] snap_sel, restore_sel;
    logic core_stall, restore_stb, viol;
    logic [DW-1:0] restore_word;
    logic [DW-1:0] img [NW];

    int checks = 0, errors = 0, cycles = 0;
    int prog = 0, good = 0, pend = 0, ckw = 0, rb_cnt = 0, rb_bad = 0;
    bit in_rb = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    ckr_ctrl #(.NREGS(NREGS), .DW(DW), .PERIOD(PERIOD), .MIN_GAP(MIN_GAP),
               .RESET_PC(RESET_PC)) u0 (
        .clk(clk), .rst(rst), .detect_i(detect), .snap_word_i(snap_word),
        .snap_sel_o(snap_sel), .core_stall_o(core_stall), .restore_stb_o(restore_stb),
        .restore_sel_o(restore_sel), .restore_word_o(restore_word),
        .progress_violation_o(viol));

    // core model: each word advances by (index+1) per unstalled cycle
    assign snap_word = img[snap_sel];
    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NW; i++) img[i] <= (i == 0) ? DW'(RESET_PC) : '0;
        end else if (restore_stb) begin
            img[restore_sel] <= restore_word;
        end else if (!core_stall) begin
            for (int i = 0; i < NW; i++) img[i] <= img[i] + DW'(i + 1);
        end
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 200000) begin
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            $display("CHECKS %0d ERRORS %0d", checks + 1, errors + 1);
            $finish;
        end
    end

    function automatic logic [DW-1:0] exp_word(int i, int p);
        return DW'(((i == 0) ? RESET_PC : 0) + (i + 1) * p);
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic step();
        bit st = core_stall, rb = restore_stb;
        int sel = int'(restore_sel);
        if (rst) begin
            prog = 0; good = 0; pend = 0; ckw = 0; in_rb = 0; rb_cnt = 0;
        end else begin
            if (rb) begin
                if (sel != rb_cnt) rb_bad++;
                if (restore_word != exp_word(sel, good)) rb_bad++;
                rb_cnt++;
            end
            if (detect) begin
                in_rb = 1; ckw = 0; rb_cnt = 0;
            end else if (st && !rb && !in_rb) begin
                if (ckw == 0) pend = prog;
                ckw++;
                if (ckw == NW) begin good = pend; ckw = 0; end
            end
            if (!st) prog++;
            if (rb && !detect && sel == NW - 1) begin prog = good; in_rb = 0; end
        end
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1; detect = 0;
        repeat (3) step();
        rst = 0;
    endtask

    task automatic wait_rise(output int n);
        n = 0;
        while (!core_stall && n < 2000) begin step(); n++; end
    endtask

    task automatic finish_restore();
        int lim = 0;
        while (core_stall && lim < 200) begin step(); lim++; end
    endtask

    task automatic rollback(int len);
        int hold_bad = 0;
        bit started;
        rb_bad = 0;
        detect = 1;
        for (int i = 0; i < len; i++) begin
            step();
            if (!core_stall || restore_stb) hold_bad++;
        end
        detect = 0;
        step();
        started = restore_stb;
        finish_restore();
        chk(hold_bad == 0, "R4", "stall/no-strobe while detect high", hold_bad, 0);
        chk(started && rb_cnt == NW, "R5", "restore strobe length", rb_cnt, NW);
        chk(rb_bad == 0, "R6", "restored words match last checkpoint", rb_bad, 0);
    endtask

    initial begin
        int n;
        int bad;
        @(negedge clk);
        do_reset();
        // R1 reset state
        chk(!core_stall && !restore_stb && !viol, "R1", "outputs after reset",
            {core_stall, restore_stb, viol}, 0);

        // R2 first checkpoint timing and length
        wait_rise(n);
        chk(n == PERIOD, "R2", "edges to first checkpoint", n, PERIOD);
        n = 0; bad = 0;
        while (core_stall && n < 100) begin
            if (int'(snap_sel) != n || restore_stb) bad++;
            step(); n++;
        end
        chk(n == NW && bad == 0, "R2", "checkpoint stall cycles", n, NW);

        // R8 detect before any checkpoint
        do_reset();
        repeat (40) step();
        rollback(2);
        chk(img[0] == DW'(RESET_PC) && img[1] == '0, "R8", "power-on image restored",
            int'(img[0]), RESET_PC);

        // R3 period restarts after restore
        wait_rise(n);
        chk(n == PERIOD, "R3", "edges from restore to checkpoint", n, PERIOD);

        // R7 detect in the middle of the second checkpoint write
        do_reset();
        wait_rise(n);
        finish_restore();
        wait_rise(n);
        repeat (3) step();
        rollback(2);
        chk(img[0] == DW'(RESET_PC + PERIOD), "R7", "older slot restored",
            int'(img[0]), RESET_PC + PERIOD);

        // R9 detect during a restore
        do_reset();
        repeat (200) step();
        rb_bad = 0;
        detect = 1; step(); detect = 0;
        repeat (4) step();
        detect = 1; repeat (2) step(); detect = 0;
        step();
        chk(restore_stb && restore_sel == '0, "R9", "restore restarts at word 0",
            int'(restore_sel), 0);
        finish_restore();
        chk(rb_cnt == NW && rb_bad == 0, "R9", "full restore after interruption", rb_cnt, NW);
        chk(img[0] == DW'(RESET_PC + PERIOD), "R9", "restored PC", int'(img[0]),
            RESET_PC + PERIOD);

        // R10 gap boundary: k = MIN_GAP-1 violates
        do_reset();
        repeat (20) step();
        rollback(1);
        chk(!viol, "R10", "no flag on first rollback", viol, 0);
        repeat (MIN_GAP - 2) step();
        rollback(1);
        chk(viol, "R10", "flag at k = MIN_GAP-1", viol, 1);
        do_reset();
        chk(!viol, "R1", "flag cleared by reset", viol, 0);
        repeat (20) step();
        rollback(1);
        repeat (MIN_GAP - 1) step();
        rollback(1);
        chk(!viol, "R10", "no flag at k = MIN_GAP", viol, 0);

        // vector table walk (R6, R10)
        do_reset();
        for (int t = 0; t < NTBL; t++) begin
            repeat (TBL[t][0]) step();
            rollback(TBL[t][1]);
            chk(viol == TBL[t][2][0], "R10", $sformatf("table entry %0d flag", t),
                viol, TBL[t][2]);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule